// File: doc/BRIEF.md
# Accumulator Instruction Sequencer

This block is a small processor with a single accumulator. It runs a multi-cycle fetch, decode and execute loop. Every access to main memory goes through two registers: an address register that drives the memory address lines, and a data register that captures data read from memory or holds data to be written. A program counter selects the next instruction. An instruction register holds the word being decoded. Results build up in a 32-bit accumulator.

Memory is reached through one port with separate read and write strobes and a ready input. A strobe stays high until memory answers with ready, so memories with any latency can be attached. The instruction set covers load, store, add, increment, decrement and a halt code. Execution is strictly sequential. The halt code parks the sequencer and raises a flag, so a test environment can then inspect the accumulator and memory.

Top module: `acc_seq_core`

## Requirements
- R1: An instruction is one 32-bit word. Bits [31:24] hold the opcode and bits [23:0] hold the operand address. Opcodes: 0x01 load, 0x02 store, 0x03 add, 0x04 increment, 0x05 decrement, 0xFF halt.
- R2: Fetch timing. There is one cycle with no strobe while the address register takes the program counter. Then `mem_rd` is high with `mem_addr` equal to the program counter until the ready cycle. Then come one instruction-load cycle and one decode cycle, both with no strobe.
- R3: `mem_rd` or `mem_wr` stays high, with the address and write data unchanged, until the cycle in which `mem_ready` is high. The strobe is low in the next cycle. The two strobes are never high together.
- R4: The program counter rises by one per instruction, so successive fetches read addresses 0, 1, 2, and so on.
- R5: Load (0x01): after decode, a read of the operand address follows. One further cycle then copies the returned word into the accumulator.
- R6: Add (0x03): the same read sequence as load. The accumulator then becomes accumulator plus the returned word, modulo 2^32.
- R7: Store (0x02): after decode, `mem_wr` is high with `mem_addr` equal to the operand address and `mem_wdata` equal to the accumulator. The addressed word is replaced.
- R8: Increment (0x04) and decrement (0x05) change the accumulator by one, wrapping modulo 2^32, at the end of the decode cycle. They make no memory access.
- R9: Any other opcode leaves the accumulator unchanged and makes no memory access. The next fetch follows the decode cycle.
- R10: Halt (0xFF): from the cycle after decode, `halted` stays high. No strobe is raised and the accumulator does not change until reset.
- R11: Reset is synchronous and active low. It clears the program counter, accumulator, instruction, address and data registers and the halt flag. After release, the first fetch reads address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | AW (24) | Memory address, driven from the address register |
| mem_wdata | output | DW (32) | Write data, driven from the data register |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_wr | output | 1 | Write strobe, held until ready |
| mem_rdata | input | DW (32) | Read data, valid in the ready cycle |
| mem_ready | input | 1 | Memory has completed the current access |
| acc_value | output | DW (32) | Current accumulator contents |
| halted | output | 1 | High once a halt instruction has been decoded |

## Verification
The bench varies the memory latency from zero to three wait cycles between accesses. A design that dropped a strobe early, or captured read data before ready, would show a wrong address sequence or a wrong accumulator. Adds and decrements that cross the 32-bit boundary expose a carry that is not truncated. A store followed by an add of the same location catches a write that never lands or lands at a stale address. An undefined opcode that carries a valid-looking operand address catches a decoder that starts a memory access for it. A reset applied while the sequencer is halted, with a nonzero accumulator and address register, catches state that survives reset.

// File: rtl/acc_seq_pkg.sv
// Package: shared encodings for the accumulator sequencer.
// Holds the opcode field width, the opcode values, the accumulator
// source selector and the control word passed from the state machine
// to the register file. Nothing in here depends on the data width.
package acc_seq_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [OPC_W-1:0] {
        OPC_LOAD  = 8'h01,
        OPC_STORE = 8'h02,
        OPC_ADD   = 8'h03,
        OPC_INC   = 8'h04,
        OPC_DEC   = 8'h05,
        OPC_HALT  = 8'hFF
    } opc_e;

    typedef enum logic [1:0] {
        ACC_SRC_MDR = 2'd0,
        ACC_SRC_ADD = 2'd1,
        ACC_SRC_INC = 2'd2,
        ACC_SRC_DEC = 2'd3
    } acc_src_e;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR,
        ST_FETCH_WAIT,
        ST_IR_LOAD,
        ST_DECODE,
        ST_OPND_WAIT,
        ST_EXECUTE,
        ST_STORE_WAIT,
        ST_HALT
    } seq_state_e;

    typedef struct packed {
        logic     mar_from_pc;
        logic     mar_from_ir;
        logic     mdr_from_mem;
        logic     mdr_from_acc;
        logic     ir_load;
        logic     pc_inc;
        logic     acc_load;
        acc_src_e acc_src;
    } seq_ctrl_t;

endpackage

// File: rtl/acc_seq_alu.sv
// Module: accumulator arithmetic unit.
// Produces the next accumulator value from the current accumulator and
// the memory data register, according to the source selector.
// Assumes: purely combinational; all results wrap modulo 2^DW.
module acc_seq_alu
    import acc_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  acc_src_e        src,
    input  logic [DW-1:0]   acc,
    input  logic [DW-1:0]   mdr,
    output logic [DW-1:0]   result
);

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    // Select the arithmetic result for the accumulator.
    always_comb begin
        unique case (src)
            ACC_SRC_MDR: result = mdr;
            ACC_SRC_ADD: result = acc + mdr;
            ACC_SRC_INC: result = acc + ONE;
            ACC_SRC_DEC: result = acc - ONE;
            default:     result = acc;
        endcase
    end

endmodule

// File: rtl/acc_seq_regs.sv
// Module: architectural and transfer registers of the sequencer.
// Holds PC, MAR, MDR, IR and ACC. Each register loads only when the
// control word asks for it. MAR drives the memory address and MDR
// drives the write data. IR exposes its opcode field to the control.
// Assumes: synchronous active-low reset; at most one MAR and one MDR
// source is requested in any cycle.
module acc_seq_regs
    import acc_seq_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = DW - acc_seq_pkg::OPC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_ctrl_t          ctrl,
    input  logic [DW-1:0]      mem_rdata,
    input  logic [DW-1:0]      alu_result,
    output logic [AW-1:0]      pc_q,
    output logic [AW-1:0]      mar_q,
    output logic [DW-1:0]      mdr_q,
    output logic [DW-1:0]      acc_q,
    output logic [OPC_W-1:0]   opcode
);

    localparam logic [AW-1:0] PC_STEP = {{(AW-1){1'b0}}, 1'b1};

    logic [DW-1:0] ir_q;

    // Program counter: cleared on reset, stepped once per instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)            pc_q <= '0;
        else if (ctrl.pc_inc)  pc_q <= pc_q + PC_STEP;
    end

    // Memory address register: takes PC for fetch or IR address for operands.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mar_q <= '0;
        else if (ctrl.mar_from_pc)  mar_q <= pc_q;
        else if (ctrl.mar_from_ir)  mar_q <= ir_q[AW-1:0];
    end

    // Memory data register: captures read data or stages the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mdr_q <= '0;
        else if (ctrl.mdr_from_mem)  mdr_q <= mem_rdata;
        else if (ctrl.mdr_from_acc)  mdr_q <= acc_q;
    end

    // Instruction register: loaded from MDR once a fetch completes.
    always_ff @(posedge clk) begin
        if (!rst_n)             ir_q <= '0;
        else if (ctrl.ir_load)  ir_q <= mdr_q;
    end

    // Accumulator: loaded from the arithmetic unit when requested.
    always_ff @(posedge clk) begin
        if (!rst_n)              acc_q <= '0;
        else if (ctrl.acc_load)  acc_q <= alu_result;
    end

    assign opcode = ir_q[DW-1 -: OPC_W];

endmodule

// File: rtl/acc_seq_ctrl.sv
// Module: control state machine of the sequencer.
// Steps through fetch, instruction load, decode and, where needed, an
// operand read, an execute cycle or a write. Strobes are decoded from
// the registered state, so they are stable for a whole cycle.
// Assumes: mem_ready is only meaningful while a strobe is high.
module acc_seq_ctrl
    import acc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              mem_ready,
    output seq_ctrl_t         ctrl,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              halted
);

    seq_state_e state_q;
    seq_state_e state_d;

    // State register with synchronous active-low reset into fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH_ADDR;
        else        state_q <= state_d;
    end

    // Next state, control word and memory strobes for the current state.
    always_comb begin
        state_d = state_q;
        ctrl    = '0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        unique case (state_q)
            ST_FETCH_ADDR: begin
                ctrl.mar_from_pc = 1'b1;
                state_d          = ST_FETCH_WAIT;
            end
            ST_FETCH_WAIT: begin
                mem_rd = 1'b1;
                if (mem_ready) begin
                    ctrl.mdr_from_mem = 1'b1;
                    state_d           = ST_IR_LOAD;
                end
            end
            ST_IR_LOAD: begin
                ctrl.ir_load = 1'b1;
                ctrl.pc_inc  = 1'b1;
                state_d      = ST_DECODE;
            end
            ST_DECODE: begin
                state_d = ST_FETCH_ADDR;
                case (opcode)
                    OPC_LOAD, OPC_ADD: begin
                        ctrl.mar_from_ir = 1'b1;
                        state_d          = ST_OPND_WAIT;
                    end
                    OPC_STORE: begin
                        ctrl.mar_from_ir  = 1'b1;
                        ctrl.mdr_from_acc = 1'b1;
                        state_d           = ST_STORE_WAIT;
                    end
                    OPC_INC: begin
                        ctrl.acc_load = 1'b1;
                        ctrl.acc_src  = ACC_SRC_INC;
                    end
                    OPC_DEC: begin
                        ctrl.acc_load = 1'b1;
                        ctrl.acc_src  = ACC_SRC_DEC;
                    end
                    OPC_HALT: state_d = ST_HALT;
                    default:  state_d = ST_FETCH_ADDR;
                endcase
            end
            ST_OPND_WAIT: begin
                mem_rd = 1'b1;
                if (mem_ready) begin
                    ctrl.mdr_from_mem = 1'b1;
                    state_d           = ST_EXECUTE;
                end
            end
            ST_EXECUTE: begin
                ctrl.acc_load = 1'b1;
                ctrl.acc_src  = (opcode == OPC_LOAD) ? ACC_SRC_MDR : ACC_SRC_ADD;
                state_d       = ST_FETCH_ADDR;
            end
            ST_STORE_WAIT: begin
                mem_wr = 1'b1;
                if (mem_ready) state_d = ST_FETCH_ADDR;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_FETCH_ADDR;
        endcase
    end

    assign halted = (state_q == ST_HALT);

endmodule

// File: rtl/acc_seq_core.sv
// Module: top of the accumulator sequencer.
// Connects the control state machine, the register file and the
// arithmetic unit. Memory address and write data come straight from
// MAR and MDR, so every memory transfer passes through them.
// Assumes: one memory access in flight at a time; memory answers each
// strobe with a one-cycle ready pulse.
module acc_seq_core
    import acc_seq_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = DW - acc_seq_pkg::OPC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           mem_rd,
    output logic           mem_wr,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ready,
    output logic [DW-1:0]  acc_value,
    output logic           halted
);

    seq_ctrl_t          ctrl;
    logic [OPC_W-1:0]   opcode;
    logic [AW-1:0]      pc_q;
    logic [AW-1:0]      mar_q;
    logic [DW-1:0]      mdr_q;
    logic [DW-1:0]      acc_q;
    logic [DW-1:0]      alu_result;

    acc_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (opcode),
        .mem_ready (mem_ready),
        .ctrl      (ctrl),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .halted    (halted)
    );

    acc_seq_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl),
        .mem_rdata  (mem_rdata),
        .alu_result (alu_result),
        .pc_q       (pc_q),
        .mar_q      (mar_q),
        .mdr_q      (mdr_q),
        .acc_q      (acc_q),
        .opcode     (opcode)
    );

    acc_seq_alu #(.DW(DW)) u_alu (
        .src    (ctrl.acc_src),
        .acc    (acc_q),
        .mdr    (mdr_q),
        .result (alu_result)
    );

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign acc_value = acc_q;

endmodule

// File: rtl/acc_seq_core_chk.sv
// Module: protocol and state checker for the accumulator sequencer.
// Watches the memory port, the halt flag and the program counter.
// Attached to every acc_seq_core instance through the bind below.
// Assumes: reset is held low for at least one rising edge at start-up.
module acc_seq_core_chk #(
    parameter int DW = 32,
    parameter int AW = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mem_rd,
    input  logic           mem_wr,
    input  logic           mem_ready,
    input  logic [AW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  acc_value,
    input  logic           halted,
    input  logic [AW-1:0]  pc
);

    logic rst_edge_seen = 1'b0;

    // Remember whether the last rising edge happened with reset applied.
    always @(posedge clk) rst_edge_seen <= !rst_n;

    // R11: state is cleared while reset is held.
    always @(negedge clk) begin
        if (rst_edge_seen && !rst_n) begin
            assert_reset_clear_R11: assert (acc_value == '0 && !halted && !mem_rd
                                            && !mem_wr && mem_addr == '0 && pc == '0)
                else $error("reset did not clear sequencer state");
        end
    end

    assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    assert_strobe_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && mem_ready) |=> (!mem_rd && !mem_wr));

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc != $past(pc)) |-> (pc == $past(pc) + 1'b1));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_rd && !mem_wr && $stable(acc_value)));

endmodule

bind acc_seq_core acc_seq_core_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .acc_value (acc_value),
    .halted    (halted),
    .pc        (pc_q)
);

// File: tb/acc_seq_core_tb.sv
// Bench: a behavioural reference walks each program instruction by
// instruction, predicts every cycle of the memory port and accumulator,
// drives the memory ready line, and compares on every falling edge.
module acc_seq_core_tb;

    localparam int DW       = 32;
    localparam int AW       = 24;
    localparam int CLK_PER  = 10;
    localparam int MEM_N    = 64;
    localparam int WDOG_CYC = 20000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic           mem_rd;
    logic           mem_wr;
    logic [DW-1:0]  mem_rdata;
    logic           mem_ready = 1'b0;
    logic [DW-1:0]  acc_value;
    logic           halted;

    logic [DW-1:0]  bmem [MEM_N];
    logic [DW-1:0]  rmem [MEM_N];

    int  n_chk  = 0;
    int  n_fail = 0;
    int  lat_idx = 0;
    bit  done = 1'b0;

    logic [DW-1:0]  exp_acc;
    logic           exp_halt;

    always #(CLK_PER/2) clk = ~clk;

    acc_seq_core #(.DW(DW), .AW(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .acc_value (acc_value),
        .halted    (halted)
    );

    // Memory behind the port: combinational read, write on the ready edge.
    assign mem_rdata = bmem[mem_addr[5:0]];
    always @(posedge clk) begin
        if (mem_wr && mem_ready) bmem[mem_addr[5:0]] <= mem_wdata;
    end

    function automatic logic [DW-1:0] ins(input logic [7:0] op, input logic [AW-1:0] a);
        return {op, a};
    endfunction

    function automatic int next_lat();
        lat_idx++;
        return (lat_idx * 5 + 2) % 4;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // One cycle: compare outputs on the falling edge, then drive ready.
    task automatic tick(input logic erd, input logic ewr, input logic [AW-1:0] eaddr,
                        input logic [DW-1:0] ewd, input logic rdy, input string req);
        @(negedge clk);
        chk(req, "mem_rd", DW'(mem_rd), DW'(erd));
        chk(req, "mem_wr", DW'(mem_wr), DW'(ewr));
        chk(req, "halted", DW'(halted), DW'(exp_halt));
        chk(req, "acc_value", acc_value, exp_acc);
        if (erd || ewr) chk(req, "mem_addr", DW'(mem_addr), DW'(eaddr));
        if (ewr)        chk(req, "mem_wdata", mem_wdata, ewd);
        mem_ready = rdy;
    endtask

    task automatic put(input int a, input logic [DW-1:0] v);
        bmem[a] = v;
        rmem[a] = v;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_N; i++) put(i, '0);
    endtask

    // Hold reset across two edges, check cleared state (R11), release.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        mem_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        exp_acc  = '0;
        exp_halt = 1'b0;
        chk("R11", "acc_value", acc_value, '0);
        chk("R11", "halted", DW'(halted), '0);
        chk("R11", "strobes", DW'({mem_rd, mem_wr}), '0);
        chk("R11", "mem_addr", DW'(mem_addr), '0);
        rst_n = 1'b1;
    endtask

    // Reference: run instructions from rmem until a halt is decoded.
    task automatic run_prog();
        logic [AW-1:0] pc = '0;
        logic [7:0]    op;
        logic [AW-1:0] a;
        int            l;
        bit            first = 1'b1;
        bit            stop = 1'b0;
        for (int n = 0; n < 40 && !stop; n++) begin
            if (!first) tick(0, 0, '0, '0, 0, "R2");
            l = next_lat();
            for (int k = 0; k <= l; k++)
                tick(1, 0, pc, '0, k == l, first ? "R11" : "R4");
            first = 1'b0;
            op = rmem[pc[5:0]][31:24];
            a  = rmem[pc[5:0]][AW-1:0];
            tick(0, 0, '0, '0, 0, "R2");
            pc = pc + 1'b1;
            tick(0, 0, '0, '0, 0, "R1");
            case (op)
                8'h01, 8'h03: begin
                    l = next_lat();
                    for (int k = 0; k <= l; k++)
                        tick(1, 0, a, '0, k == l, (op == 8'h01) ? "R5" : "R6");
                    tick(0, 0, '0, '0, 0, (op == 8'h01) ? "R5" : "R6");
                    exp_acc = (op == 8'h01) ? rmem[a[5:0]] : exp_acc + rmem[a[5:0]];
                end
                8'h02: begin
                    l = next_lat();
                    for (int k = 0; k <= l; k++)
                        tick(0, 1, a, exp_acc, k == l, "R7");
                    rmem[a[5:0]] = exp_acc;
                end
                8'h04: exp_acc = exp_acc + 1;
                8'h05: exp_acc = exp_acc - 1;
                8'hFF: begin
                    exp_halt = 1'b1;
                    stop = 1'b1;
                    for (int k = 0; k < 6; k++) tick(0, 0, '0, '0, 0, "R10");
                end
                default: ;
            endcase
        end
        if (!stop) chk("R10", "halt reached", 0, 1);
    endtask

    // Compare memory contents with the reference copy.
    task automatic check_mem(input string req);
        for (int i = 40; i < 48; i++) chk(req, "memory word", bmem[i], rmem[i]);
    endtask

    initial begin
        exp_acc  = '0;
        exp_halt = 1'b0;
        // Program 1: load, add with wrap (R6), store over old data (R7),
        // inc/dec (R8), undefined opcode with an address (R9), halt (R10).
        clear_mem();
        put(40, 32'h0000_0005);
        put(41, 32'hFFFF_FFFD);
        put(42, 32'hDEAD_BEEF);
        put(43, 32'h1234_5678);
        put(0, ins(8'h01, 24'd40));
        put(1, ins(8'h03, 24'd41));
        put(2, ins(8'h02, 24'd42));
        put(3, ins(8'h04, 24'd0));
        put(4, ins(8'h04, 24'd0));
        put(5, ins(8'h05, 24'd0));
        put(6, ins(8'h77, 24'd42));
        put(7, ins(8'h03, 24'd42));
        put(8, ins(8'h02, 24'd43));
        put(9, ins(8'hFF, 24'd0));
        do_reset();
        run_prog();
        check_mem("R7");
        chk("R6", "final acc", acc_value, 32'h0000_0005);

        // Program 2: reset from halted state (R11), decrement through zero,
        // store then add the same word, nop opcode 0x00 (R9).
        clear_mem();
        put(44, 32'h5555_5555);
        put(45, 32'h0000_00A0);
        put(0, ins(8'h05, 24'd0));
        put(1, ins(8'h02, 24'd44));
        put(2, ins(8'h04, 24'd0));
        put(3, ins(8'h03, 24'd44));
        put(4, ins(8'h04, 24'd0));
        put(5, ins(8'h01, 24'd45));
        put(6, ins(8'h00, 24'd45));
        put(7, ins(8'hFF, 24'd0));
        do_reset();
        run_prog();
        check_mem("R7");
        chk("R5", "final acc", acc_value, 32'h0000_00A0);
        chk("R8", "stored wrap value", bmem[44], 32'hFFFF_FFFF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule